// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Divider Bank

This block turns one parent clock into six per-domain clock-enable streams. The domains are processor, DSP, DSP memory-management unit, fabric (the on-chip traffic controller), display and peripheral. Each domain divides the parent by 1, 2, 4 or 8, chosen by a 2-bit exponent. All six exponents live in one 16-bit control word, and the block owns that word.

Software changes the word in one of two ways. It can write the whole word with a strobe. It can also issue a rate request for one domain, giving a target frequency and the current parent rate. A set request picks the exponent and applies it. A round request only reports the rate that would result.

Every new word passes through a legalizer before it is stored. The legalizer raises or clamps exponents so that the required ordering of domain frequencies always holds. New exponents reach the divider counters only at a shared divide-by-8 boundary, so no domain ever emits a shortened period.

Top module: `clkdiv_bank`

## Requirements
- R1: A domain whose active exponent is e asserts its clk_en bit once every 2^e parent cycles, so 16 consecutive cycles hold 16>>e pulses.
- R2: The stored memory-management exponent (bits [5:4]) is clamped up to the DSP exponent (bits [3:2]) when it is lower, and down to the DSP exponent plus one when it is higher than that.
- R3: The stored fabric exponent (bits [7:6]) is raised to at least the processor exponent (bits [1:0]) and to at least the clamped memory-management exponent.
- R4: The display exponent (bits [9:8]) and the peripheral exponent (bits [11:10]) are raised to at least the final fabric exponent.
- R5: Bits [15:12] of a written word are stored unchanged.
- R6: A rate request for a domain code (0 processor, 1 DSP, 2 memory-management, 3 fabric, 4 display, 5 peripheral) chooses the smallest exponent e for which parent_rate>>e is at or below req_rate. One cycle later rsp_valid is high and rsp_exp holds e. rsp_rate holds parent_rate>>e. rsp_ok is high when that rate meets the target.
- R7: When even exponent 3 is too fast, a round request returns rsp_exp 3, the exponent-3 rate and rsp_ok low. A set request in that case, or a set request with a domain code of 6 or 7, returns rsp_ok low and rsp_rate 0, and leaves the word unchanged.
- R8: The clamps are applied in a fixed order: memory-management first, then fabric, then display and peripheral. So a raise of memory-management carries into fabric and onward.
- R9: Counting parent cycles from reset release, new exponents take effect only on every eighth cycle. Until then each domain keeps its old pulse pattern, and pulses of exponent 3 fall on that boundary.
- R10: In reset the word is 0 and clk_en is 0. After the first cycle out of reset every domain divides by 1.
- R11: A write strobe stores the legalized word, which can be read on cfg_rdata in the next cycle. A write in the same cycle as a set request wins, and the set request reports rsp_ok low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to legalize and store |
| cfg_rdata | output | 16 | Stored legalized control word |
| parent_rate | input | 32 | Parent frequency used by rate requests |
| req_valid | input | 1 | Rate request strobe |
| req_set | input | 1 | 1 = set request, 0 = round request |
| req_dom | input | 3 | Domain code of the request |
| req_rate | input | 32 | Target frequency |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_ok | output | 1 | Target met (and applied for set) |
| rsp_exp | output | 2 | Chosen exponent |
| rsp_rate | output | 32 | Resulting rate, 0 for a rejected set |
| clk_en | output | 6 | Per-domain clock-enable pulses, bit = domain code |

## Verification
The legalizer is driven with several kinds of word. One is a word that is already legal, and it must come back unchanged. One breaks only the processor-to-fabric order. One leaves display below fabric. Others push the memory-management exponent out of its band from below and from above. Together these show which clamp fires and whether its result carries into the next stage. The rate path is tried with targets that land exactly on a power-of-two rate, targets between two such rates, and a target below the slowest rate; the last case separates the round behaviour from the set behaviour. Enable streams are counted over windows long enough for every exponent, and one reload is timed against the eight-cycle boundary to show that the old pattern persists until that boundary.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int EXP_W   = 2;
  localparam int NUM_DOM = 6;
  localparam int WORD_W  = 16;
  localparam int DOM_W   = 3;
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int FLD_W   = NUM_DOM * EXP_W;
  localparam int KEEP_W  = WORD_W - FLD_W;

  typedef enum logic [DOM_W-1:0] {
    DOM_PROC = 3'd0,
    DOM_DSP  = 3'd1,
    DOM_MMU  = 3'd2,
    DOM_FAB  = 3'd3,
    DOM_DISP = 3'd4,
    DOM_PERI = 3'd5
  } dom_e;

  function automatic logic [EXP_W-1:0] fld_get(input logic [WORD_W-1:0] w, input dom_e d);
    return w[int'(d)*EXP_W +: EXP_W];
  endfunction

  function automatic logic [EXP_W-1:0] exp_max(input logic [EXP_W-1:0] a, input logic [EXP_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clkdiv_legalizer.sv
module clkdiv_legalizer
  import clkdiv_pkg::*;
(
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] legal_word
);
  logic [EXP_W-1:0] e_proc, e_dsp, e_mmu, e_fab, e_disp, e_peri;
  logic [EXP_W-1:0] mmu_lo, mmu_c, fab_c, disp_c, peri_c;
  logic [EXP_W:0]   dsp_up;

  always_comb begin
    e_proc = fld_get(raw_word, DOM_PROC);
    e_dsp  = fld_get(raw_word, DOM_DSP);
    e_mmu  = fld_get(raw_word, DOM_MMU);
    e_fab  = fld_get(raw_word, DOM_FAB);
    e_disp = fld_get(raw_word, DOM_DISP);
    e_peri = fld_get(raw_word, DOM_PERI);
  end

  // stage 1: memory-management band around the DSP exponent
  always_comb begin
    dsp_up = {1'b0, e_dsp} + 1'b1;
    mmu_lo = exp_max(e_mmu, e_dsp);
    if ({1'b0, mmu_lo} > dsp_up) mmu_c = dsp_up[EXP_W-1:0];
    else                         mmu_c = mmu_lo;
  end

  // stage 2: fabric no faster than processor or clamped memory-management
  always_comb fab_c = exp_max(exp_max(e_fab, e_proc), mmu_c);

  // stage 3: display and peripheral no faster than fabric
  always_comb begin
    disp_c = exp_max(e_disp, fab_c);
    peri_c = exp_max(e_peri, fab_c);
  end

  always_comb begin
    legal_word = raw_word;
    legal_word[int'(DOM_MMU)*EXP_W  +: EXP_W] = mmu_c;
    legal_word[int'(DOM_FAB)*EXP_W  +: EXP_W] = fab_c;
    legal_word[int'(DOM_DISP)*EXP_W +: EXP_W] = disp_c;
    legal_word[int'(DOM_PERI)*EXP_W +: EXP_W] = peri_c;
  end
endmodule

// File: rtl/clkdiv_rate_solver.sv
module clkdiv_rate_solver
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic [RATE_W-1:0] parent_rate,
  input  logic [RATE_W-1:0] target_rate,
  output logic [EXP_W-1:0]  exp_o,
  output logic              fits_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [MAX_EXP:0] fits;

  genvar g;
  generate
    for (g = 0; g <= MAX_EXP; g++) begin : g_cand
      assign fits[g] = (parent_rate >> g) <= target_rate;
    end
  endgenerate

  // smallest fitting exponent wins; scan from slow to fast
  always_comb begin
    exp_o  = EXP_W'(MAX_EXP);
    fits_o = 1'b0;
    for (int e = MAX_EXP; e >= 0; e--) begin
      if (fits[e]) begin
        exp_o  = EXP_W'(e);
        fits_o = 1'b1;
      end
    end
  end

  assign rate_o = parent_rate >> exp_o;
endmodule

// File: rtl/clkdiv_domain_tick.sv
module clkdiv_domain_tick
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sync,
  input  logic [MAX_EXP-1:0] phase,
  input  logic [EXP_W-1:0]   exp_new,
  output logic               tick_o
);
  logic [EXP_W-1:0]   exp_q;
  logic [MAX_EXP-1:0] mask;

  always_comb begin
    for (int b = 0; b < MAX_EXP; b++) mask[b] = (b < int'(exp_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (phase & mask) == mask;
      if (sync) exp_q <= exp_new;
    end
  end

  p_hold_until_sync_r9: assert property (@(posedge clk) disable iff (rst)
    !sync |=> $stable(exp_q));
  p_slowest_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick_o && exp_q == EXP_W'(MAX_EXP) && $past(exp_q) == EXP_W'(MAX_EXP)) |=> !tick_o);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic [RATE_W-1:0]   parent_rate,
  input  logic                req_valid,
  input  logic                req_set,
  input  logic [DOM_W-1:0]    req_dom,
  input  logic [RATE_W-1:0]   req_rate,
  output logic                rsp_valid,
  output logic                rsp_ok,
  output logic [EXP_W-1:0]    rsp_exp,
  output logic [RATE_W-1:0]   rsp_rate,
  output logic [NUM_DOM-1:0]  clk_en
);
  logic [WORD_W-1:0]  ctl_word, req_word, leg_in, leg_out;
  logic [EXP_W-1:0]   sol_exp;
  logic               sol_fits, dom_ok, set_go;
  logic [RATE_W-1:0]  sol_rate;
  logic [MAX_EXP-1:0] phase;
  logic               sync;

  clkdiv_rate_solver #(.RATE_W(RATE_W)) u_solver (
    .parent_rate (parent_rate),
    .target_rate (req_rate),
    .exp_o       (sol_exp),
    .fits_o      (sol_fits),
    .rate_o      (sol_rate)
  );

  assign dom_ok = int'(req_dom) < NUM_DOM;
  assign set_go = req_valid && req_set && sol_fits && dom_ok && !cfg_wr;

  always_comb begin
    req_word = ctl_word;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (req_dom == DOM_W'(d)) req_word[d*EXP_W +: EXP_W] = sol_exp;
    end
    leg_in = cfg_wr ? cfg_wdata : req_word;
  end

  clkdiv_legalizer u_legal (
    .raw_word   (leg_in),
    .legal_word (leg_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                  ctl_word <= '0;
    else if (cfg_wr || set_go) ctl_word <= leg_out;
  end
  assign cfg_rdata = ctl_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_exp   <= '0;
      rsp_rate  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_exp   <= sol_exp;
      rsp_ok    <= req_set ? set_go : sol_fits;
      rsp_rate  <= (req_set && !set_go) ? '0 : sol_rate;
    end
  end

  // common reload boundary every 2^MAX_EXP cycles
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end
  assign sync = &phase;

  genvar g;
  generate
    for (g = 0; g < NUM_DOM; g++) begin : g_dom
      clkdiv_domain_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .sync    (sync),
        .phase   (phase),
        .exp_new (ctl_word[g*EXP_W +: EXP_W]),
        .tick_o  (clk_en[g])
      );
    end
  endgenerate

  p_mmu_band_r2: assert property (@(posedge clk) disable iff (rst)
    (fld_get(ctl_word, DOM_MMU) >= fld_get(ctl_word, DOM_DSP)) &&
    ({1'b0, fld_get(ctl_word, DOM_MMU)} <= {1'b0, fld_get(ctl_word, DOM_DSP)} + 1'b1));
  p_fabric_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (fld_get(ctl_word, DOM_FAB) >= fld_get(ctl_word, DOM_PROC)) &&
    (fld_get(ctl_word, DOM_FAB) >= fld_get(ctl_word, DOM_MMU)));
  p_slow_side_r4: assert property (@(posedge clk) disable iff (rst)
    (fld_get(ctl_word, DOM_DISP) >= fld_get(ctl_word, DOM_FAB)) &&
    (fld_get(ctl_word, DOM_PERI) >= fld_get(ctl_word, DOM_FAB)));
  p_keep_bits_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> ctl_word[WORD_W-1 -: KEEP_W] == $past(cfg_wdata[WORD_W-1 -: KEEP_W]));
  p_met_rate_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> rsp_rate <= $past(req_rate));
  p_reject_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok && $past(req_set && !cfg_wr)) |-> $stable(ctl_word));
endmodule

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [31:0] parent_rate = 32'd96_000_000;
  logic        req_valid = 1'b0;
  logic        req_set = 1'b0;
  logic [2:0]  req_dom = '0;
  logic [31:0] req_rate = '0;
  logic        rsp_valid, rsp_ok;
  logic [1:0]  rsp_exp;
  logic [31:0] rsp_rate;
  logic [5:0]  clk_en;

  int n_run = 0;
  int n_bad = 0;
  int edge_n = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  clkdiv_bank u_clkdiv_bank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .parent_rate(parent_rate), .req_valid(req_valid), .req_set(req_set), .req_dom(req_dom),
    .req_rate(req_rate), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_exp(rsp_exp),
    .rsp_rate(rsp_rate), .clk_en(clk_en)
  );

  // {written word, expected stored word}
  localparam logic [31:0] VEC [8] = '{
    {16'hF000, 16'hF000},  // R5 top bits only
    {16'h0003, 16'h0FC3},  // R3 processor drags fabric, R4 follows
    {16'h0008, 16'h0AA8},  // R8 mmu raise carries into fabric and beyond
    {16'hA030, 16'hA550},  // R2 mmu clamped down to dsp+1, R5
    {16'h0BA5, 16'h0BA5},  // R11 legal word unchanged
    {16'h5180, 16'h5A80},  // R4 display and peripheral raised
    {16'h301C, 16'h3FFC},  // R2 mmu raised to dsp
    {16'hFFFF, 16'hFFFF}   // R11 all slowest
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [15:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rate_req(input logic set, input logic [2:0] dom, input logic [31:0] tgt);
    req_valid = 1'b1; req_set = set; req_dom = dom; req_rate = tgt;
    @(negedge clk);
    req_valid = 1'b0; req_set = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset word", {16'h0, cfg_rdata}, 32'h0);
    chk("R10 reset enables", {26'h0, clk_en}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 divide-by-1 after reset", {26'h0, clk_en}, 32'h3F);

    // R9: write all-slowest right now (captured at edge 2), reload at edge 8
    cfg_wr = 1'b1; cfg_wdata = 16'hFFFF;
    for (int k = 2; k <= 16; k++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      chk($sformatf("R9 reload edge %0d", edge_n), {26'h0, clk_en},
          ((edge_n <= 8) || (edge_n % 8 == 0)) ? 32'h3F : 32'h0);
    end

    // legalizer vector walk
    for (int i = 0; i < 8; i++) begin
      wr_word(VEC[i][31:16]);
      chk($sformatf("R11 legal word vec %0d", i), {16'h0, cfg_rdata}, {16'h0, VEC[i][15:0]});
    end

    // R1 pulse density for exps proc1 dsp1 mmu2 fab2 disp3 peri2
    wr_word(16'h0BA5);
    repeat (16) @(negedge clk);
    begin
      int cnt [6];
      int want [6];
      want = '{8, 8, 4, 4, 2, 4};
      for (int d = 0; d < 6; d++) cnt[d] = 0;
      for (int c = 0; c < 16; c++) begin
        for (int d = 0; d < 6; d++) cnt[d] += int'(clk_en[d]);
        @(negedge clk);
      end
      for (int d = 0; d < 6; d++) chk($sformatf("R1 density dom %0d", d), cnt[d], want[d]);
    end

    // R6 round requests
    rate_req(1'b0, 3'd0, 32'd50_000_000);
    chk("R6 round 50M exp", {30'h0, rsp_exp}, 32'd1);
    chk("R6 round 50M rate", rsp_rate, 32'd48_000_000);
    chk("R6 round 50M ok", {31'h0, rsp_ok & rsp_valid}, 32'd1);
    rate_req(1'b0, 3'd4, 32'd96_000_000);
    chk("R6 round exact parent exp", {30'h0, rsp_exp}, 32'd0);
    rate_req(1'b0, 3'd5, 32'd12_000_000);
    chk("R6 round 12M exp", {30'h0, rsp_exp}, 32'd3);
    chk("R6 round 12M ok", {31'h0, rsp_ok}, 32'd1);
    rate_req(1'b0, 3'd1, 32'd11_000_000);
    chk("R7 round too fast exp", {30'h0, rsp_exp}, 32'd3);
    chk("R7 round too fast rate", rsp_rate, 32'd12_000_000);
    chk("R7 round too fast ok", {31'h0, rsp_ok}, 32'd0);

    // R7 rejected set requests
    wr_word(16'h0000);
    rate_req(1'b1, 3'd1, 32'd11_000_000);
    chk("R7 set too fast ok", {31'h0, rsp_ok}, 32'd0);
    chk("R7 set too fast rate", rsp_rate, 32'd0);
    chk("R7 set too fast word", {16'h0, cfg_rdata}, 32'h0);
    rate_req(1'b1, 3'd6, 32'd24_000_000);
    chk("R7 set bad domain ok", {31'h0, rsp_ok}, 32'd0);
    chk("R7 set bad domain word", {16'h0, cfg_rdata}, 32'h0);

    // R6 accepted set on DSP, legalized (R2/R3/R4)
    rate_req(1'b1, 3'd1, 32'd24_000_000);
    chk("R6 set dsp ok", {31'h0, rsp_ok}, 32'd1);
    chk("R6 set dsp rate", rsp_rate, 32'd24_000_000);
    chk("R6 set dsp word", {16'h0, cfg_rdata}, 32'h0AA8);

    // R11 write beats simultaneous set
    wr_word(16'h0000);
    cfg_wr = 1'b1; cfg_wdata = 16'h0003;
    rate_req(1'b1, 3'd1, 32'd96_000_000);
    cfg_wr = 1'b0;
    chk("R11 write wins word", {16'h0, cfg_rdata}, 32'h0FC3);
    chk("R11 write wins set ok", {31'h0, rsp_ok}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule